// File: doc/BRIEF.md
# Signed Sum-Versus-Operand Comparator

This block answers one question about three signed words: is the sum of the first two at least as large as the third? All three operands are WIDTH-bit two's complement values. The only result is a single flag. There is no carry-lookahead and no prefix network. A row of three-input bit cells first reduces the first operand, the second operand and the bit-inverted third operand to a sum word and a carry word. One ripple adder then adds those two words, with a carry-in of one, which completes the two's complement negation of the third operand. The delay through the ripple therefore grows by one cell per bit.

The whole computation runs at WIDTH+2 bits after sign extension. The difference a + b - c can never leave that range, so the sign of the difference is always exact. The flag is the inverse of that sign bit. A sum that overflows WIDTH bits therefore never gives a wrong answer.

A LATENCY parameter sets how many registers follow the flag. With LATENCY = 0 the path is purely combinational. With LATENCY = 1 or more, the flag is delayed by that many clock edges, and a synchronous active-high reset clears every stage.

Top module: `addcmp_ge`

## Requirements
- R1: `ge_o` is 1 exactly when op_a + op_b >= op_c, each port read as a WIDTH-bit two's complement integer. This holds for every combination of operand values.
- R2: When op_a + op_b is larger than the largest positive WIDTH-bit value, `ge_o` is 1, whatever op_c is.
- R3: When op_a + op_b is smaller than the most negative WIDTH-bit value, `ge_o` is 0, whatever op_c is.
- R4: When op_a + op_b equals op_c exactly, `ge_o` is 1.
- R5: With LATENCY = L > 0, `ge_o` shows the result for the operands that were present L rising edges earlier. New operands applied between edges do not change `ge_o` until the next edge. With LATENCY = 0, `ge_o` follows the operands with no clock.
- R6: With LATENCY > 0, every rising edge that samples `rst` high drives `ge_o` to 0 on that edge, whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stages |
| rst | input | 1 | Synchronous active-high reset of the output stages |
| op_a | input | WIDTH | First addend, two's complement |
| op_b | input | WIDTH | Second addend, two's complement |
| op_c | input | WIDTH | Operand compared against the sum, two's complement |
| ge_o | output | 1 | 1 when op_a + op_b >= op_c |

## Verification
Two cases can arise on the same vector: the sum op_a + op_b overflows WIDTH bits, and the sum lands exactly on the tie with op_c or one step from it. A plain WIDTH-bit adder gets exactly these vectors wrong. The bench produces every such vector by sweeping all operand triples of a 5-bit instance, and it also walks the extreme values of an 8-bit combinational instance. Each result is compared with an integer-arithmetic expectation, and each vector is labelled by the case it falls into: overflow, tie, or ordinary.

// File: rtl/addcmp_pkg.sv
package addcmp_pkg;

    // Guard bits added above the operand width so that a + b - c never overflows.
    localparam int unsigned GUARD_BITS = 2;

    typedef struct packed {
        logic sum;
        logic carry;
    } fa_res_t;

    function automatic fa_res_t full_add(input logic x, input logic y, input logic z);
        fa_res_t r;
        r.sum   = x ^ y ^ z;
        r.carry = (x & y) | (x & z) | (y & z);
        return r;
    endfunction

endpackage

// File: rtl/addcmp_csa_row.sv
module addcmp_csa_row
    import addcmp_pkg::*;
#(
    parameter int unsigned W = 10
) (
    input  logic [W-1:0] in_x,
    input  logic [W-1:0] in_y,
    input  logic [W-1:0] in_z,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] cy_o
);

    // The carry word is already shifted one place to the left. Bit 0 is free;
    // the ripple stage feeds its carry-in there instead.
    assign cy_o[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_cell
        if (i < W - 1) begin : g_full
            fa_res_t r;
            assign r          = full_add(in_x[i], in_y[i], in_z[i]);
            assign sum_o[i]   = r.sum;
            assign cy_o[i+1]  = r.carry;
        end else begin : g_top
            // The carry out of the top bit falls outside the modulo-2^W result.
            assign sum_o[i] = in_x[i] ^ in_y[i] ^ in_z[i];
        end
    end

endmodule

// File: rtl/addcmp_ripple.sv
module addcmp_ripple
    import addcmp_pkg::*;
#(
    parameter int unsigned W = 10
) (
    input  logic [W-1:0] in_p,
    input  logic [W-1:0] in_q,
    input  logic         cin,
    output logic [W-1:0] sum_o
);

    // chain[i] is the carry into bit i.
    logic [W-1:0] chain;
    assign chain[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i < W - 1) begin : g_mid
            fa_res_t r;
            assign r          = full_add(in_p[i], in_q[i], chain[i]);
            assign sum_o[i]   = r.sum;
            assign chain[i+1] = r.carry;
        end else begin : g_msb
            assign sum_o[i] = in_p[i] ^ in_q[i] ^ chain[i];
        end
    end

endmodule

// File: rtl/addcmp_delay.sv
module addcmp_delay #(
    parameter int unsigned STAGES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES:0] line;
    assign line[0] = d_i;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                line[s+1] <= 1'b0;
            end else begin
                line[s+1] <= line[s];
            end
        end
    end

    assign q_o = line[STAGES];

endmodule

// File: rtl/addcmp_ge.sv
module addcmp_ge
    import addcmp_pkg::*;
#(
    parameter int unsigned WIDTH   = 8,
    parameter int unsigned LATENCY = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [WIDTH-1:0] op_c,
    output logic             ge_o
);

    localparam int unsigned XW = WIDTH + GUARD_BITS;

    logic [XW-1:0] ext_a, ext_b, ext_cn;
    logic [XW-1:0] csa_sum, csa_cy;
    logic [XW-1:0] diff;
    logic          flag;

    // Sign-extend all three operands. The third one is inverted here; its +1
    // arrives as the ripple carry-in.
    assign ext_a  = {{GUARD_BITS{op_a[WIDTH-1]}}, op_a};
    assign ext_b  = {{GUARD_BITS{op_b[WIDTH-1]}}, op_b};
    assign ext_cn = ~{{GUARD_BITS{op_c[WIDTH-1]}}, op_c};

    addcmp_csa_row #(.W(XW)) u_csa (
        .in_x  (ext_a),
        .in_y  (ext_b),
        .in_z  (ext_cn),
        .sum_o (csa_sum),
        .cy_o  (csa_cy)
    );

    addcmp_ripple #(.W(XW)) u_rip (
        .in_p  (csa_sum),
        .in_q  (csa_cy),
        .cin   (1'b1),
        .sum_o (diff)
    );

    // A non-negative difference means the sum reaches the third operand.
    assign flag = ~diff[XW-1];

    addcmp_delay #(.STAGES(LATENCY)) u_dly (
        .clk (clk),
        .rst (rst),
        .d_i (flag),
        .q_o (ge_o)
    );

endmodule

// File: rtl/addcmp_ge_chk.sv
module addcmp_ge_chk #(
    parameter int unsigned WIDTH   = 8,
    parameter int unsigned LATENCY = 1
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic [WIDTH-1:0] op_c,
    input logic             ge_o
);

    localparam int unsigned XW = WIDTH + 2;
    localparam logic signed [XW-1:0] MAXV = {3'b000, {(WIDTH-1){1'b1}}};
    localparam logic signed [XW-1:0] MINV = {3'b111, {(WIDTH-1){1'b0}}};

    logic signed [XW-1:0] sa, sb, sc, sab;
    logic exp_ge, pos_ovf, neg_ovf, tie;

    // The expected result is computed with plain signed arithmetic.
    assign sa      = XW'($signed(op_a));
    assign sb      = XW'($signed(op_b));
    assign sc      = XW'($signed(op_c));
    assign sab     = sa + sb;
    assign exp_ge  = (sab >= sc);
    assign pos_ovf = (sab > MAXV);
    assign neg_ovf = (sab < MINV);
    assign tie     = (sab == sc);

    if (LATENCY == 0) begin : g_comb
        a_r1_matches_integer: assert property (@(posedge clk) ge_o == exp_ge);
        a_r2_pos_overflow:    assert property (@(posedge clk) pos_ovf |-> ge_o);
        a_r3_neg_overflow:    assert property (@(posedge clk) neg_ovf |-> !ge_o);
        a_r4_tie_is_ge:       assert property (@(posedge clk) tie |-> ge_o);
    end else if (LATENCY == 1) begin : g_reg
        a_r1_matches_integer: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> ge_o == $past(exp_ge));
        a_r2_pos_overflow:    assert property (@(posedge clk) disable iff (rst)
            pos_ovf |=> ge_o);
        a_r3_neg_overflow:    assert property (@(posedge clk) disable iff (rst)
            neg_ovf |=> !ge_o);
        a_r4_tie_is_ge:       assert property (@(posedge clk) disable iff (rst)
            tie |=> ge_o);
        a_r5_holds_between_edges: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) && $stable(exp_ge) |=> $stable(ge_o));
    end

    if (LATENCY > 0) begin : g_rst
        a_r6_reset_clears: assert property (@(posedge clk) rst |=> !ge_o);
    end

endmodule

bind addcmp_ge addcmp_ge_chk #(.WIDTH(WIDTH), .LATENCY(LATENCY)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .op_a (op_a),
    .op_b (op_b),
    .op_c (op_c),
    .ge_o (ge_o)
);

// File: tb/addcmp_ge_bench.sv
module addcmp_ge_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;   // 50 MHz

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Registered 5-bit instance, swept over every operand triple.
    logic [4:0] a5 = '0, b5 = '0, c5 = '0;
    logic       ge5;

    addcmp_ge #(.WIDTH(5), .LATENCY(1)) u_addcmp_ge (
        .clk (clk), .rst (rst),
        .op_a (a5), .op_b (b5), .op_c (c5),
        .ge_o (ge5)
    );

    // Combinational 8-bit instance at the default width.
    logic [7:0] a8 = '0, b8 = '0, c8 = '0;
    logic       ge8;

    addcmp_ge #(.WIDTH(8), .LATENCY(0)) u_addcmp_ge_comb (
        .clk (clk), .rst (rst),
        .op_a (a8), .op_b (b8), .op_c (c8),
        .ge_o (ge8)
    );

    task automatic check(input logic got, input logic exp, input string req, input string ctx);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %b expected %b", req, ctx, got, exp);
        end
    endtask

    function automatic string classify(input int s, input int c, input int lo, input int hi);
        if (s > hi)  return "R2";
        if (s < lo)  return "R3";
        if (s == c)  return "R4";
        return "R1";
    endfunction

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        int sa, sb, sc;
        // R6: reset with operands that would give 1 (0 + 0 >= 0).
        @(negedge clk);
        check(ge5, 1'b0, "R6", "during reset");
        @(negedge clk);
        check(ge5, 1'b0, "R6", "during reset second cycle");
        rst = 1'b0;
        @(negedge clk);
        check(ge5, 1'b1, "R5", "first edge after reset");

        // R5: operands change between edges; the output waits for the edge.
        a5 = 5'd0; b5 = 5'd0; c5 = 5'd1;   // 0 >= 1 is false
        #1;
        check(ge5, 1'b1, "R5", "held before edge");
        @(negedge clk);
        check(ge5, 1'b0, "R5", "updated after edge");

        // R6: reset asserted mid-stream clears the flag.
        a5 = 5'd3; b5 = 5'd3; c5 = 5'd0;
        @(negedge clk);
        check(ge5, 1'b1, "R1", "6 >= 0");
        rst = 1'b1;
        @(negedge clk);
        check(ge5, 1'b0, "R6", "reset mid-stream");
        rst = 1'b0;
        @(negedge clk);

        // R1..R4: every triple of the 5-bit instance, one vector per cycle.
        for (int i = -16; i < 16; i++) begin
            for (int j = -16; j < 16; j++) begin
                for (int k = -16; k < 16; k++) begin
                    a5 = i[4:0]; b5 = j[4:0]; c5 = k[4:0];
                    @(negedge clk);
                    check(ge5, ((i + j) >= k), classify(i + j, k, -16, 15),
                          $sformatf("w5 a=%0d b=%0d c=%0d", i, j, k));
                end
            end
        end

        // Extreme values on the 8-bit combinational instance.
        begin
            int vals [7] = '{-128, -127, -1, 0, 1, 126, 127};
            foreach (vals[x]) foreach (vals[y]) foreach (vals[z]) begin
                a8 = vals[x][7:0]; b8 = vals[y][7:0]; c8 = vals[z][7:0];
                #2;
                check(ge8, ((vals[x] + vals[y]) >= vals[z]),
                      classify(vals[x] + vals[y], vals[z], -128, 127),
                      $sformatf("w8 a=%0d b=%0d c=%0d", vals[x], vals[y], vals[z]));
            end
        end

        // Random vectors on the 8-bit instance; half of them are forced to a tie.
        for (int n = 0; n < 3000; n++) begin
            a8 = 8'($urandom); b8 = 8'($urandom);
            sa = $signed(a8); sb = $signed(b8);
            if (n % 2 == 0 && (sa + sb) >= -128 && (sa + sb) <= 127) c8 = 8'(sa + sb);
            else c8 = 8'($urandom);
            sc = $signed(c8);
            #2;
            check(ge8, ((sa + sb) >= sc), classify(sa + sb, sc, -128, 127),
                  $sformatf("w8 rnd a=%0d b=%0d c=%0d", sa, sb, sc));
        end

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (120000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule